// File: doc/BRIEF.md
# Interrupt Polarity, Mask and Latch Front End

This block sits between a set of peripheral interrupt sources and a parent controller that only accepts active-high level requests. Each source line first crosses into the block clock domain through a two-stage synchroniser. It can then be inverted by a per-line polarity bit, so that active-low or falling-edge sources are seen as active-high. The line is then either passed straight through, if it is level type, or captured in a sticky per-line latch, if it is edge type. A per-line mask bit gates the result onto the output vector. Every line of that vector is an active-high level.

Software reaches three register banks through a word-addressed write port and a combinational read port. The banks are mask, polarity and end-of-interrupt. Each register is 16 bits wide and covers 16 lines. Writing 1 to a line's end-of-interrupt bit releases that line's latch. Whether each line is edge or level type is fixed by a build-time vector. A build option removes the end-of-interrupt bank altogether. In that build, edge latches can only be released by reset.

Each edge line is a two-state machine. The states are `LN_IDLE` (nothing pending) and `LN_HELD` (a request is latched). It has three transitions:
- `T_CAPTURE` (IDLE to HELD): taken when an active edge of the polarity-corrected input arrives.
- `T_CLEAR` (HELD to IDLE): taken when an end-of-interrupt bit is written for the line and no edge arrives in the same cycle.
- `T_KEEP` (HELD to HELD): taken when an edge arrives in the same cycle as the end-of-interrupt. The edge wins.

Level lines never leave `LN_IDLE`.

Top module: `irqfe_top`

## Requirements
- R1: After reset, every implemented mask bit reads 1, every polarity bit reads 0, no latch is held, and every output is 0.
- R2: The word address selects a bank with bits [3:2] (0 = mask, 1 = polarity, 2 = end-of-interrupt, 3 = none) and a register with bits [1:0]. Line n sits at bit n mod 16 of register n / 16. Bits and registers beyond the configured line count read 0, and writes to them have no effect.
- R3: A mask bit of 1 forces the line's output to 0. A mask bit of 0 lets the line's output through.
- R4: A polarity bit of 1 inverts the synchronised input before level use and edge detection. A polarity bit of 0 leaves it unchanged.
- R5: A level-type line drives output = corrected input AND NOT mask, two clock edges after the input changes. End-of-interrupt writes do not affect it.
- R6: An edge-type line latches on a 0-to-1 transition of its corrected input. The line's output rises three clock edges after the raw input. It stays high after the input returns, until a 1 is written to the line's end-of-interrupt bit.
- R7: An edge that arrives while the line is masked is still latched. It appears on the output as soon as the mask bit is cleared.
- R8: When an edge is detected in the same cycle as an end-of-interrupt write for that line, the latch stays set.
- R9: The end-of-interrupt bank always reads 0. A 0 written to one of its bits leaves that line's latch unchanged.
- R10: With the end-of-interrupt bank omitted at build time, writes to it leave every latch set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NUM_LINES | Raw interrupt sources, asynchronous |
| reg_addr | input | 4 | Word address: bank in [3:2], register in [1:0] |
| reg_wr_en | input | 1 | Write strobe, one cycle per write |
| reg_wr_data | input | 16 | Write data |
| reg_rd_data | output | 16 | Combinational read data for reg_addr |
| irq_out | output | NUM_LINES | Active-high level requests to the parent |

## Verification
Four properties are checked on every cycle:
- a masked line never drives its output;
- the end-of-interrupt bank reads zero;
- a held latch is only released by an end-of-interrupt pulse for its own line;
- an edge that meets an end-of-interrupt pulse leaves the latch set.

The masks are also checked to come out of reset all set.

Some behaviour can only be shown by the bench's scenarios, because it depends on sequences of register writes and input waveforms:
- the exact address decode;
- polarity inversion producing a falling-edge capture;
- the pass-through and latency of level lines;
- an edge captured under mask and revealed on unmask;
- the build without end-of-interrupt.

// File: rtl/irqfe_pkg.sv
package irqfe_pkg;

    localparam int MAX_LINES = 64;
    localparam int REG_W     = 16;
    localparam int ADDR_W    = 4;
    localparam int IDX_W     = 2;

    typedef enum logic [1:0] {
        BANK_MASK = 2'd0,
        BANK_POL  = 2'd1,
        BANK_EOI  = 2'd2,
        BANK_NONE = 2'd3
    } bank_e;

    typedef enum logic {
        LN_IDLE = 1'b0,
        LN_HELD = 1'b1
    } line_state_e;

endpackage

// File: rtl/irqfe_sync.sv
module irqfe_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] stable_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= d_i;
            stable_q <= meta_q;
        end
    end

    assign q_o = stable_q;

endmodule

// File: rtl/irqfe_regs.sv
module irqfe_regs
    import irqfe_pkg::*;
#(
    parameter int N       = 64,
    parameter bit HAS_EOI = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [REG_W-1:0]  wr_data_i,
    output logic [REG_W-1:0]  rd_data_o,
    output logic [N-1:0]      mask_o,
    output logic [N-1:0]      pol_o,
    output logic [N-1:0]      eoi_o
);

    bank_e            bank;
    logic [IDX_W-1:0] idx;
    logic [N-1:0]     mask_q;
    logic [N-1:0]     pol_q;
    logic [MAX_LINES-1:0] mask_pad;
    logic [MAX_LINES-1:0] pol_pad;

    assign bank = bank_e'(addr_i[ADDR_W-1:IDX_W]);
    assign idx  = addr_i[IDX_W-1:0];

    for (genvar n = 0; n < N; n++) begin : g_bit
        localparam logic [IDX_W-1:0] WORD = IDX_W'(n / REG_W);
        localparam int               BIT  = n % REG_W;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_q[n] <= 1'b1;
                pol_q[n]  <= 1'b0;
            end else if (wr_en_i && idx == WORD) begin
                if (bank == BANK_MASK) mask_q[n] <= wr_data_i[BIT];
                if (bank == BANK_POL)  pol_q[n]  <= wr_data_i[BIT];
            end
        end

        if (HAS_EOI) begin : g_eoi
            assign eoi_o[n] = wr_en_i && (bank == BANK_EOI) && (idx == WORD) && wr_data_i[BIT];
        end else begin : g_no_eoi
            assign eoi_o[n] = 1'b0;
        end
    end

    always_comb begin
        mask_pad         = '0;
        pol_pad          = '0;
        mask_pad[N-1:0]  = mask_q;
        pol_pad[N-1:0]   = pol_q;
        rd_data_o        = '0;
        unique case (bank)
            BANK_MASK: rd_data_o = mask_pad[idx*REG_W +: REG_W];
            BANK_POL:  rd_data_o = pol_pad[idx*REG_W +: REG_W];
            BANK_EOI:  rd_data_o = '0;
            BANK_NONE: rd_data_o = '0;
        endcase
    end

    assign mask_o = mask_q;
    assign pol_o  = pol_q;

endmodule

// File: rtl/irqfe_line.sv
module irqfe_line
    import irqfe_pkg::*;
#(
    parameter bit IS_EDGE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_i,
    input  logic pol_i,
    input  logic mask_i,
    input  logic eoi_i,
    output logic irq_o,
    output logic held_o,
    output logic edge_o
);

    line_state_e state_q;
    line_state_e state_d;
    logic        corr;
    logic        corr_q;

    assign corr = sync_i ^ pol_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) corr_q <= 1'b0;
        else        corr_q <= corr;
    end

    assign edge_o = IS_EDGE ? (corr & ~corr_q) : 1'b0;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LN_IDLE;
        else        state_q <= state_d;
    end

    // transitions: T_CAPTURE, T_CLEAR, T_KEEP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LN_IDLE: if (edge_o)            state_d = LN_HELD;
            LN_HELD: if (eoi_i && !edge_o)  state_d = LN_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        held_o = (state_q == LN_HELD);
        irq_o  = (IS_EDGE ? held_o : corr) & ~mask_i;
    end

endmodule

// File: rtl/irqfe_top.sv
module irqfe_top
    import irqfe_pkg::*;
#(
    parameter int                   NUM_LINES  = 64,
    parameter logic [MAX_LINES-1:0] EDGE_LINES = 64'hFFFF_FFFF_0000_0000,
    parameter bit                   HAS_EOI    = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr_en,
    input  logic [REG_W-1:0]     reg_wr_data,
    output logic [REG_W-1:0]     reg_rd_data,
    output logic [NUM_LINES-1:0] irq_out
);

    logic [NUM_LINES-1:0] sync_w;
    logic [NUM_LINES-1:0] mask_w;
    logic [NUM_LINES-1:0] pol_w;
    logic [NUM_LINES-1:0] eoi_w;
    logic [NUM_LINES-1:0] held_w;
    logic [NUM_LINES-1:0] edge_w;

    irqfe_sync #(.W(NUM_LINES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (irq_in),
        .q_o   (sync_w)
    );

    irqfe_regs #(.N(NUM_LINES), .HAS_EOI(HAS_EOI)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (reg_addr),
        .wr_en_i   (reg_wr_en),
        .wr_data_i (reg_wr_data),
        .rd_data_o (reg_rd_data),
        .mask_o    (mask_w),
        .pol_o     (pol_w),
        .eoi_o     (eoi_w)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        irqfe_line #(.IS_EDGE(EDGE_LINES[i])) line_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .sync_i (sync_w[i]),
            .pol_i  (pol_w[i]),
            .mask_i (mask_w[i]),
            .eoi_i  (eoi_w[i]),
            .irq_o  (irq_out[i]),
            .held_o (held_w[i]),
            .edge_o (edge_w[i])
        );
    end

endmodule

// File: rtl/irqfe_chk.sv
module irqfe_chk
    import irqfe_pkg::*;
#(
    parameter int N = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [REG_W-1:0]  reg_rd_data,
    input logic [N-1:0]      irq_out,
    input logic [N-1:0]      mask_w,
    input logic [N-1:0]      held_w,
    input logic [N-1:0]      edge_w,
    input logic [N-1:0]      eoi_w
);

    AST_RESET_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (&mask_w)); // R1

    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out & mask_w) == '0); // R3

    AST_EOI_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr[ADDR_W-1:IDX_W] == BANK_EOI) |-> (reg_rd_data == '0)); // R9

    AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(held_w) & ~$past(eoi_w) & ~held_w) == '0)); // R6

    AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ((edge_w & eoi_w) != '0) |=> (($past(edge_w & eoi_w) & ~held_w) == '0)); // R8

endmodule

bind irqfe_top irqfe_chk #(.N(NUM_LINES)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_addr    (reg_addr),
    .reg_rd_data (reg_rd_data),
    .irq_out     (irq_out),
    .mask_w      (mask_w),
    .held_w      (held_w),
    .edge_w      (edge_w),
    .eoi_w       (eoi_w)
);

// File: tb/irqfe_top_tb_top.sv
`timescale 1ns/1ps
module irqfe_top_tb_top;

    localparam int N = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_in = '0;
    logic [3:0]    reg_addr = '0;
    logic          reg_wr_en = 1'b0;
    logic [15:0]   reg_wr_data = '0;
    logic [15:0]   rd_a, rd_b;
    logic [N-1:0]  out_a, out_b;
    int            n_chk = 0;
    int            n_bad = 0;
    bit            done = 1'b0;

    always #2 clk = ~clk;

    irqfe_top #(.NUM_LINES(N), .EDGE_LINES(64'h0FF00), .HAS_EOI(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_addr(reg_addr),
        .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_data(rd_a), .irq_out(out_a));

    irqfe_top #(.NUM_LINES(N), .EDGE_LINES(64'h0FF00), .HAS_EOI(1'b0)) dut_ne_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_addr(reg_addr),
        .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_data(rd_b), .irq_out(out_b));

    // {input, polarity, mask, expected} on level lines 0..7
    localparam logic [31:0] VEC [6] = '{
        32'h00_00_00_00,
        32'hA5_00_00_A5,
        32'hA5_FF_00_5A,
        32'h3C_0F_F0_03,
        32'hFF_00_55_AA,
        32'h00_81_01_80
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wcyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wr_data = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = rd_a;
    endtask

    task automatic pulse(input int line);
        @(negedge clk); irq_in[line] = 1'b1;
        @(negedge clk); irq_in[line] = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

    initial begin
        logic [15:0] r;
        wcyc(3);
        rst_n = 1'b1;
        wcyc(2);

        // R1 reset state
        chk("R1 outputs", 32'(out_a), 32'h0);
        rd(4'h0, r); chk("R1 mask word0", 32'(r), 32'hFFFF);
        rd(4'h1, r); chk("R1 mask word1 (R2 unused bits)", 32'(r), 32'h000F);
        rd(4'h4, r); chk("R1 polarity word0", 32'(r), 32'h0000);

        // R3 R4 R5 vector table on level lines
        foreach (VEC[k]) begin
            wr(4'h0, {8'hFF, VEC[k][15:8]});
            wr(4'h4, {8'h00, VEC[k][23:16]});
            @(negedge clk); irq_in[7:0] = VEC[k][31:24];
            wcyc(4);
            chk("R3/R4/R5 table", 32'(out_a[15:0]), {16'h0, 8'h00, VEC[k][7:0]});
        end
        irq_in = '0;
        wr(4'h4, 16'h0000);
        wr(4'h0, 16'hFFFF);
        wcyc(3);

        // R6 edge latch and EOI; R9; R10
        wr(4'h0, 16'hFEFF);
        pulse(8);
        wcyc(4);
        chk("R6 latched", 32'(out_a[8]), 32'h1);
        wcyc(3);
        chk("R6 held after input low", 32'(out_a[8]), 32'h1);
        wr(4'h8, 16'hFEFF);
        wcyc(2);
        chk("R9 zero EOI bit no effect", 32'(out_a[8]), 32'h1);
        rd(4'h8, r); chk("R9 EOI reads zero", 32'(r), 32'h0);
        wr(4'h8, 16'h0100);
        wcyc(2);
        chk("R6 EOI clears", 32'(out_a[8]), 32'h0);
        chk("R10 no-EOI build keeps latch", 32'(out_b[8]), 32'h1);

        // R7 masked capture
        wr(4'h0, 16'hFFFF);
        pulse(8);
        wcyc(4);
        chk("R7 masked output low", 32'(out_a[8]), 32'h0);
        wr(4'h0, 16'hFEFF);
        chk("R7 shown on unmask", 32'(out_a[8]), 32'h1);
        wr(4'h8, 16'h0100);
        wcyc(2);

        // R4 falling-edge capture through polarity
        wr(4'h0, 16'hFDFF);
        @(negedge clk); irq_in[9] = 1'b1;
        wcyc(4);
        chk("R6 rising edge line 9", 32'(out_a[9]), 32'h1);
        wr(4'h4, 16'h0200);
        wr(4'h8, 16'h0200);
        wcyc(4);
        chk("R4 inverted no edge", 32'(out_a[9]), 32'h0);
        @(negedge clk); irq_in[9] = 1'b0;
        wcyc(4);
        chk("R4 falling edge latched", 32'(out_a[9]), 32'h1);
        wr(4'h8, 16'h0200);
        wr(4'h4, 16'h0000);
        wr(4'h8, 16'h0200);
        wcyc(2);

        // R8 edge and EOI in the same cycle
        wr(4'h0, 16'hFBFF);
        pulse(10);
        wcyc(4);
        chk("R8 pre-latched", 32'(out_a[10]), 32'h1);
        @(negedge clk); irq_in[10] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        reg_addr = 4'h8; reg_wr_data = 16'h0400; reg_wr_en = 1'b1;
        @(negedge clk); reg_wr_en = 1'b0;
        wcyc(2);
        chk("R8 edge wins over EOI", 32'(out_a[10]), 32'h1);
        wr(4'h8, 16'h0400);
        wcyc(2);
        chk("R8 later EOI clears", 32'(out_a[10]), 32'h0);
        @(negedge clk); irq_in[10] = 1'b0;
        wcyc(3);

        // R5 level line ignores EOI
        wr(4'h0, 16'hFFFE);
        @(negedge clk); irq_in[0] = 1'b1;
        wcyc(4);
        chk("R5 level high", 32'(out_a[0]), 32'h1);
        wr(4'h8, 16'h0001);
        wcyc(2);
        chk("R5 EOI ignored", 32'(out_a[0]), 32'h1);
        @(negedge clk); irq_in[0] = 1'b0;
        wcyc(4);
        chk("R5 level follows low", 32'(out_a[0]), 32'h0);

        // R2 second register, out-of-range
        wr(4'h1, 16'hFFF0);
        rd(4'h1, r); chk("R2 word1 unused bits", 32'(r), 32'h0000);
        @(negedge clk); irq_in[16] = 1'b1;
        wcyc(4);
        chk("R2 line 16 at word1 bit0", 32'(out_a[16]), 32'h1);
        wr(4'h5, 16'h0001);
        chk("R2/R4 polarity word1 bit0", 32'(out_a[16]), 32'h0);
        rd(4'h5, r); chk("R2 polarity word1 read", 32'(r), 32'h0001);
        wr(4'h2, 16'hFFFF);
        rd(4'h2, r); chk("R2 beyond line count", 32'(r), 32'h0);
        rd(4'hC, r); chk("R2 empty bank", 32'(r), 32'h0);

        done = 1'b1;
        summary();
    end

endmodule